// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block performs exception entry for a 16/32-bit processor core that keeps two stack pointers. The core presents a request that carries a kind (trap, bus/address fault or interrupt), a vector number, the status word and program counter to save and, for faults, a bus-cycle status word, a fault address and the instruction word. The block moves into supervisor mode, clears the trace bit, exchanges the user and supervisor stack pointers when the core was in user mode, lowers the active stack pointer, and drives a series of 16-bit stack writes. It then reads the 32-bit handler address from the vector table as two 16-bit reads and returns it as the new program counter with a one-cycle done pulse.

For interrupts, the block first runs an acknowledge handshake. The outcome of that cycle picks the vector: a bus error gives the spurious vector, an autovector reply gives a vector derived from the level, and otherwise the byte on the data bus is used. The accepted level is placed into the interrupt mask of the new status word. When the sequencer is idle, the core can switch the privilege mode (the block then exchanges the stack pointers) and can load the active stack pointer.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0, `memReq`=0, `iackReq`=0, `donePulse`=0). It is in supervisor mode, `statusOut` is 16'h2700 and `a7` equals the parameter `SSP_INIT`.
- R2: On accepting a request, `superMode` becomes 1. `statusOut` takes the request status with bit 15 (trace) cleared and bit 13 (supervisor) set. If the block was in user mode, the active pointer is first saved as the user pointer and the supervisor pointer becomes the base.
- R3: A short frame is used for `reqKind` 2'b00 (trap), 2'b10 (interrupt) and 2'b11. It lowers `a7` by 6 and writes, in this order: PC bits 15:0 at base−2, the status word at base−6, then PC bits 31:16 at base−4.
- R4: A long frame is used for `reqKind` 2'b01 (fault). It lowers `a7` by 14. After the three short-frame writes it writes the instruction word at base−8, fault address bits 15:0 at base−10, the bus-cycle status word at base−14, and fault address bits 31:16 at base−12.
- R5: After the last stack write the block issues two reads: the high half at vector×4, then the low half at vector×4+2.
- R6: After the second read is acknowledged, `donePulse` is high for exactly one cycle. During that cycle `newPc` is {first read data, second read data}.
- R7: For an interrupt, the acknowledge outcome sets the vector. A bus error (`iackBerr`) gives 24. Otherwise an autovector (`iackAuto`) gives 24+level. Otherwise the vector is `iackData`. A bus error takes priority over an autovector.
- R8: For an interrupt, `statusOut[10:8]` takes `reqLevel`. For other kinds these bits keep the saved status value.
- R9: Every stack write reports `memCycleLen` = `WRITE_HALF` (default 8 half-cycles). Every vector read reports `READ_HALF` (default 8).
- R10: While busy, `reqValid`, `modeSetValid` and `spWriteValid` are ignored. The bus sequence, `a7` and `superMode` are unaffected.
- R11: When idle, `modeSetValid` with a mode different from the current one exchanges the pointers. The current `a7` is saved to the mode being left, and `a7` loads the saved pointer of the mode entered.
- R12: A request taken in supervisor mode performs no exchange. The frame base is the current `a7`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Exception request (sampled when idle) |
| reqKind | input | 2 | 00 trap, 01 fault, 10 interrupt, 11 short trap |
| reqVector | input | 8 | Vector number for trap/fault |
| reqLevel | input | 3 | Interrupt level |
| statusIn | input | 16 | Status word to save |
| pcIn | input | 32 | Program counter to save |
| busStatusIn | input | 16 | Bus-cycle status word (fault) |
| faultAddrIn | input | 32 | Faulting address (fault) |
| instrWordIn | input | 16 | Current instruction word (fault) |
| iackReq | output | 1 | Interrupt acknowledge in progress |
| iackDone | input | 1 | Acknowledge cycle finished |
| iackBerr | input | 1 | Acknowledge ended in bus error |
| iackAuto | input | 1 | Autovector requested |
| iackData | input | 8 | Vector byte from the data bus |
| memReq | output | 1 | Memory cycle request |
| memWrite | output | 1 | 1 write, 0 read |
| memAddr | output | 32 | Byte address |
| memWData | output | 16 | Write data |
| memCycleLen | output | 5 | Cycle length in half-cycles |
| memAck | input | 1 | Cycle completes at this edge |
| memRData | input | 16 | Read data |
| modeSetValid | input | 1 | Request a privilege mode change (idle only) |
| modeSetSuper | input | 1 | Target mode, 1 supervisor |
| spWriteValid | input | 1 | Load active stack pointer (idle only) |
| spWriteData | input | 32 | Value for active stack pointer |
| busy | output | 1 | Sequence in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| newPc | output | 32 | Handler address |
| a7 | output | 32 | Active stack pointer |
| superMode | output | 1 | Current privilege mode |
| statusOut | output | 16 | Current status word |

## Verification
A wrong step counter or frame-length flag shows up as the wrong address or data on the very next acknowledged stack write. The write count also comes out one short or long before the reads begin. A pointer exchange missed or doubled leaves `a7` wrong right after acceptance. It shows again as a wrong base address in the first write, and later as a wrong restored pointer when the mode is switched back. A wrong vector choice in the acknowledge path shows within one read as a wrong table address, and then as a wrong `newPc` in the done cycle.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

  localparam int ADDR_W   = 32;
  localparam int WORD_W   = 16;
  localparam int VEC_W    = 8;
  localparam int LVL_W    = 3;
  localparam int IDX_W    = 3;
  localparam int SHORT_LAST = 2;
  localparam int LONG_LAST  = 6;
  localparam int SHORT_BYTES = 6;
  localparam int LONG_BYTES  = 14;
  localparam logic [VEC_W-1:0] SPURIOUS_VEC = VEC_W'(24);
  localparam logic [VEC_W-1:0] AUTO_BASE    = VEC_W'(24);

  localparam logic [1:0] KIND_FAULT = 2'b01;
  localparam logic [1:0] KIND_INTR  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IACK, ST_PUSH, ST_FETCH_HI, ST_FETCH_LO, ST_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    SRC_PC_LO, SRC_STATUS, SRC_PC_HI, SRC_INSTR, SRC_FAULT_LO, SRC_BUS_STAT, SRC_FAULT_HI
  } pushSrc_t;

  typedef struct packed {
    logic             accept;
    logic             iackLatch;
    logic             pushActive;
    logic [IDX_W-1:0] pushIdx;
    logic             fetchLow;
    logic             latchHi;
    logic             latchLo;
    logic             modeSwap;
    logic             spWrite;
  } seqStrobe_t;

  // Byte distance below the frame base for each push step.
  function automatic logic [3:0] pushOffset(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0: pushOffset = 4'd2;
      3'd1: pushOffset = 4'd6;
      3'd2: pushOffset = 4'd4;
      3'd3: pushOffset = 4'd8;
      3'd4: pushOffset = 4'd10;
      3'd5: pushOffset = 4'd14;
      default: pushOffset = 4'd12;
    endcase
  endfunction

  function automatic pushSrc_t pushSource(input logic [IDX_W-1:0] idx);
    pushSource = pushSrc_t'(idx);
  endfunction

endpackage

// File: rtl/exc_frame_ctrl.sv
module exc_frame_ctrl
  import exc_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       iackDone,
  input  logic       memAck,
  input  logic       modeSetValid,
  input  logic       spWriteValid,
  output seqStrobe_t strobe,
  output logic       iackReq,
  output logic       memReq,
  output logic       memWrite,
  output logic       busy,
  output logic       donePulse
);

  seqState_t        state, stateNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             longFrame, longNext;
  logic             isIdle;
  logic             lastPush;

  assign isIdle   = (state == ST_IDLE);
  assign lastPush = longFrame ? (idx == IDX_W'(LONG_LAST)) : (idx == IDX_W'(SHORT_LAST));

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    longNext  = longFrame;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          longNext  = (reqKind == KIND_FAULT);
          idxNext   = '0;
          stateNext = (reqKind == KIND_INTR) ? ST_IACK : ST_PUSH;
        end
      end
      ST_IACK: if (iackDone) stateNext = ST_PUSH;
      ST_PUSH: begin
        if (memAck) begin
          if (lastPush) stateNext = ST_FETCH_HI;
          else          idxNext   = idx + 1'b1;
        end
      end
      ST_FETCH_HI: if (memAck) stateNext = ST_FETCH_LO;
      ST_FETCH_LO: if (memAck) stateNext = ST_DONE;
      ST_DONE:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      longFrame <= 1'b0;
    end else begin
      state     <= stateNext;
      idx       <= idxNext;
      longFrame <= longNext;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.accept     = isIdle && reqValid;
    strobe.modeSwap   = isIdle && !reqValid && modeSetValid;
    strobe.spWrite    = isIdle && !reqValid && !modeSetValid && spWriteValid;
    strobe.iackLatch  = (state == ST_IACK) && iackDone;
    strobe.pushActive = (state == ST_PUSH);
    strobe.pushIdx    = idx;
    strobe.fetchLow   = (state == ST_FETCH_LO);
    strobe.latchHi    = (state == ST_FETCH_HI) && memAck;
    strobe.latchLo    = (state == ST_FETCH_LO) && memAck;
  end

  assign iackReq   = (state == ST_IACK);
  assign memReq    = (state == ST_PUSH) || (state == ST_FETCH_HI) || (state == ST_FETCH_LO);
  assign memWrite  = (state == ST_PUSH);
  assign busy      = !isIdle;
  assign donePulse = (state == ST_DONE);

endmodule

// File: rtl/exc_frame_dp.sv
module exc_frame_dp
  import exc_frame_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SSP_INIT   = 32'h0000_1000,
  parameter int                WRITE_HALF = 8,
  parameter int                READ_HALF  = 8,
  parameter int                LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        reqKind,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic [WORD_W-1:0] statusIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [WORD_W-1:0] busStatusIn,
  input  logic [ADDR_W-1:0] faultAddrIn,
  input  logic [WORD_W-1:0] instrWordIn,
  input  logic              iackBerr,
  input  logic              iackAuto,
  input  logic [VEC_W-1:0]  iackData,
  input  logic [WORD_W-1:0] memRData,
  input  logic              modeSetSuper,
  input  logic [ADDR_W-1:0] spWriteData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [LEN_W-1:0]  memCycleLen,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] a7,
  output logic              superMode,
  output logic [WORD_W-1:0] statusOut
);

  logic [ADDR_W-1:0] uspSaved, sspSaved, frameBase;
  logic [ADDR_W-1:0] pcSaved, faultSaved;
  logic [WORD_W-1:0] statusSaved, busStatSaved, instrSaved, hiWord;
  logic [VEC_W-1:0]  vecReg, iackVec;
  logic [ADDR_W-1:0] entryBase, tableAddr;
  logic [3:0]        frameBytes;
  logic [WORD_W-1:0] newStatus;

  assign entryBase  = superMode ? a7 : sspSaved;
  assign frameBytes = (reqKind == KIND_FAULT) ? 4'(LONG_BYTES) : 4'(SHORT_BYTES);

  always_comb begin
    newStatus     = statusIn;
    newStatus[15] = 1'b0;
    newStatus[13] = 1'b1;
    if (reqKind == KIND_INTR) newStatus[10:8] = reqLevel;
  end

  always_comb begin
    if (iackBerr)      iackVec = SPURIOUS_VEC;
    else if (iackAuto) iackVec = AUTO_BASE + VEC_W'(reqLevel);
    else               iackVec = iackData;
  end

  // Pointer bank and mode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a7        <= SSP_INIT;
      uspSaved  <= '0;
      sspSaved  <= SSP_INIT;
      superMode <= 1'b1;
      statusOut <= 16'h2700;
      frameBase <= SSP_INIT;
    end else if (strobe.accept) begin
      if (!superMode) uspSaved <= a7;
      frameBase <= entryBase;
      a7        <= entryBase - ADDR_W'(frameBytes);
      superMode <= 1'b1;
      statusOut <= newStatus;
    end else if (strobe.modeSwap) begin
      if (modeSetSuper != superMode) begin
        if (superMode) begin
          sspSaved <= a7;
          a7       <= uspSaved;
        end else begin
          uspSaved <= a7;
          a7       <= sspSaved;
        end
        superMode     <= modeSetSuper;
        statusOut[13] <= modeSetSuper;
      end
    end else if (strobe.spWrite) begin
      a7 <= spWriteData;
    end
  end

  // Frame contents and vector.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSaved      <= '0;
      faultSaved   <= '0;
      statusSaved  <= '0;
      busStatSaved <= '0;
      instrSaved   <= '0;
      vecReg       <= '0;
    end else if (strobe.accept) begin
      pcSaved      <= pcIn;
      faultSaved   <= faultAddrIn;
      statusSaved  <= statusIn;
      busStatSaved <= busStatusIn;
      instrSaved   <= instrWordIn;
      vecReg       <= reqVector;
    end else if (strobe.iackLatch) begin
      vecReg <= iackVec;
    end
  end

  // Handler address assembly.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiWord <= '0;
      newPc  <= '0;
    end else if (strobe.latchHi) begin
      hiWord <= memRData;
    end else if (strobe.latchLo) begin
      newPc <= {hiWord, memRData};
    end
  end

  assign tableAddr = ADDR_W'({vecReg, 2'b00}) + (strobe.fetchLow ? ADDR_W'(2) : ADDR_W'(0));

  always_comb begin
    if (strobe.pushActive) begin
      memAddr     = frameBase - ADDR_W'(pushOffset(strobe.pushIdx));
      memCycleLen = LEN_W'(WRITE_HALF);
      case (pushSource(strobe.pushIdx))
        SRC_PC_LO:    memWData = pcSaved[15:0];
        SRC_STATUS:   memWData = statusSaved;
        SRC_PC_HI:    memWData = pcSaved[31:16];
        SRC_INSTR:    memWData = instrSaved;
        SRC_FAULT_LO: memWData = faultSaved[15:0];
        SRC_BUS_STAT: memWData = busStatSaved;
        default:      memWData = faultSaved[31:16];
      endcase
    end else begin
      memAddr     = tableAddr;
      memCycleLen = LEN_W'(READ_HALF);
      memWData    = '0;
    end
  end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter logic [31:0] SSP_INIT   = 32'h0000_1000,
  parameter int          WRITE_HALF = 8,
  parameter int          READ_HALF  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic [7:0]  reqVector,
  input  logic [2:0]  reqLevel,
  input  logic [15:0] statusIn,
  input  logic [31:0] pcIn,
  input  logic [15:0] busStatusIn,
  input  logic [31:0] faultAddrIn,
  input  logic [15:0] instrWordIn,
  output logic        iackReq,
  input  logic        iackDone,
  input  logic        iackBerr,
  input  logic        iackAuto,
  input  logic [7:0]  iackData,
  output logic        memReq,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [15:0] memWData,
  output logic [4:0]  memCycleLen,
  input  logic        memAck,
  input  logic [15:0] memRData,
  input  logic        modeSetValid,
  input  logic        modeSetSuper,
  input  logic        spWriteValid,
  input  logic [31:0] spWriteData,
  output logic        busy,
  output logic        donePulse,
  output logic [31:0] newPc,
  output logic [31:0] a7,
  output logic        superMode,
  output logic [15:0] statusOut
);

  seqStrobe_t strobe;

  exc_frame_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .iackDone(iackDone), .memAck(memAck), .modeSetValid(modeSetValid),
    .spWriteValid(spWriteValid), .strobe(strobe), .iackReq(iackReq),
    .memReq(memReq), .memWrite(memWrite), .busy(busy), .donePulse(donePulse)
  );

  exc_frame_dp #(
    .SSP_INIT(SSP_INIT), .WRITE_HALF(WRITE_HALF), .READ_HALF(READ_HALF), .LEN_W(5)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind),
    .reqVector(reqVector), .reqLevel(reqLevel), .statusIn(statusIn),
    .pcIn(pcIn), .busStatusIn(busStatusIn), .faultAddrIn(faultAddrIn),
    .instrWordIn(instrWordIn), .iackBerr(iackBerr), .iackAuto(iackAuto),
    .iackData(iackData), .memRData(memRData), .modeSetSuper(modeSetSuper),
    .spWriteData(spWriteData), .memAddr(memAddr), .memWData(memWData),
    .memCycleLen(memCycleLen), .newPc(newPc), .a7(a7),
    .superMode(superMode), .statusOut(statusOut)
  );

endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter int WRITE_HALF = 8,
  parameter int READ_HALF  = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        memReq,
  input logic        memWrite,
  input logic [31:0] memAddr,
  input logic [4:0]  memCycleLen,
  input logic        iackReq,
  input logic        donePulse,
  input logic [31:0] a7,
  input logic        superMode,
  input logic [15:0] statusOut
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !iackReq && !donePulse)); // R1

  AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (superMode && statusOut[13] && !statusOut[15])); // R2

  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> (memAddr[0] == 1'b0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R6

  AST_WRITE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (memCycleLen == 5'(WRITE_HALF))); // R9

  AST_READ_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> (memCycleLen == 5'(READ_HALF))); // R9

  AST_SP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(a7) && superMode)); // R10

endmodule

bind exc_frame_seq exc_frame_seq_chk #(.WRITE_HALF(WRITE_HALF), .READ_HALF(READ_HALF)) uChk (.*);

// File: tb/sim_exc_frame_seq.sv
module sim_exc_frame_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [7:0]  reqVector = '0;
  logic [2:0]  reqLevel = '0;
  logic [15:0] statusIn = '0;
  logic [31:0] pcIn = '0;
  logic [15:0] busStatusIn = '0;
  logic [31:0] faultAddrIn = '0;
  logic [15:0] instrWordIn = '0;
  logic        iackReq;
  logic        iackDone = 1'b0, iackBerr = 1'b0, iackAuto = 1'b0;
  logic [7:0]  iackData = '0;
  logic        memReq, memWrite;
  logic [31:0] memAddr;
  logic [15:0] memWData;
  logic [4:0]  memCycleLen;
  logic        memAck = 1'b0;
  logic [15:0] memRData = '0;
  logic        modeSetValid = 1'b0, modeSetSuper = 1'b0;
  logic        spWriteValid = 1'b0;
  logic [31:0] spWriteData = '0;
  logic        busy, donePulse, superMode;
  logic [31:0] newPc, a7;
  logic [15:0] statusOut;

  always #2.5 clk = ~clk;

  exc_frame_seq u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference model state.
  logic [31:0] mA7, mOther;   // mOther: saved pointer of the inactive mode
  logic        mSuper;
  logic [48:0] expQ[$];       // {write, addr, data}

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] tableWord(input logic [31:0] addr);
    return {addr[7:0] ^ 8'h5A, ~addr[7:0]};
  endfunction

  task automatic modelEnter(input logic [1:0] kind, output logic [31:0] base);
    if (!mSuper) begin
      logic [31:0] t;
      t = mA7; mA7 = mOther; mOther = t; mSuper = 1'b1;
    end
    base = mA7;
    mA7 = mA7 - ((kind == 2'b01) ? 32'd14 : 32'd6);
  endtask

  task automatic modeSet(input logic toSuper);
    @(negedge clk);
    modeSetValid = 1'b1; modeSetSuper = toSuper;
    @(negedge clk);
    modeSetValid = 1'b0;
    if (toSuper != mSuper) begin
      logic [31:0] t;
      t = mA7; mA7 = mOther; mOther = t; mSuper = toSuper;
    end
    chk(a7 == mA7, "R11", "a7 after mode set", a7, mA7);
    chk(superMode == mSuper, "R11", "mode after mode set", {31'd0, superMode}, {31'd0, mSuper});
  endtask

  task automatic spWrite(input logic [31:0] v);
    @(negedge clk);
    spWriteValid = 1'b1; spWriteData = v;
    @(negedge clk);
    spWriteValid = 1'b0;
    mA7 = v;
    chk(a7 == v, "R11", "a7 after load", a7, v);
  endtask

  // Runs one exception entry and serves the bus until done.
  task automatic runExc(input logic [1:0] kind, input logic [7:0] vec, input logic [2:0] lvl,
                        input logic [15:0] st, input logic [31:0] pc, input logic [15:0] bst,
                        input logic [31:0] fa, input logic [15:0] iw,
                        input bit berr, input bit autoV, input logic [7:0] ibyte,
                        input bit poke, input string req);
    logic [31:0] base, vAddr, expPc;
    logic [7:0]  v;
    logic [15:0] expSt;
    int          waitCnt, txn;
    bit          gotDone;
    @(negedge clk);
    reqKind = kind; reqVector = vec; reqLevel = lvl; statusIn = st; pcIn = pc;
    busStatusIn = bst; faultAddrIn = fa; instrWordIn = iw; reqValid = 1'b1;
    modelEnter(kind, base);
    v = vec;
    if (kind == 2'b10) v = berr ? 8'd24 : (autoV ? 8'd24 + {5'd0, lvl} : ibyte);
    expQ.delete();
    expQ.push_back({1'b1, base - 32'd2, pc[15:0]});
    expQ.push_back({1'b1, base - 32'd6, st});
    expQ.push_back({1'b1, base - 32'd4, pc[31:16]});
    if (kind == 2'b01) begin
      expQ.push_back({1'b1, base - 32'd8,  iw});
      expQ.push_back({1'b1, base - 32'd10, fa[15:0]});
      expQ.push_back({1'b1, base - 32'd14, bst});
      expQ.push_back({1'b1, base - 32'd12, fa[31:16]});
    end
    vAddr = {22'd0, v, 2'b00};
    expQ.push_back({1'b0, vAddr, 16'h0});
    expQ.push_back({1'b0, vAddr + 32'd2, 16'h0});
    expPc = {tableWord(vAddr), tableWord(vAddr + 32'd2)};
    expSt = st; expSt[15] = 1'b0; expSt[13] = 1'b1;
    if (kind == 2'b10) expSt[10:8] = lvl;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, req, "busy after accept", {31'd0, busy}, 32'd1);
    chk(a7 == mA7, "R2", "a7 after entry", a7, mA7);
    chk(statusOut == expSt, "R8", "status after entry", {16'd0, statusOut}, {16'd0, expSt});
    waitCnt = 0; txn = 0; gotDone = 1'b0;
    for (int k = 0; k < 400 && !gotDone; k++) begin
      if (k > 0) @(negedge clk);
      memAck = 1'b0; iackDone = 1'b0;
      if (poke && k == 2) begin
        reqValid = 1'b1; reqKind = 2'b01; modeSetValid = 1'b1; modeSetSuper = 1'b0;
        spWriteValid = 1'b1; spWriteData = 32'hDEAD_0000;
      end
      if (poke && k == 3) begin
        reqValid = 1'b0; modeSetValid = 1'b0; spWriteValid = 1'b0;
      end
      if (donePulse) begin
        gotDone = 1'b1;
        chk(newPc == expPc, "R6", "newPc", newPc, expPc);
        chk(expQ.size() == 0, "R5", "transactions left at done", expQ.size(), 0);
      end else if (iackReq) begin
        iackDone = 1'b1; iackBerr = berr; iackAuto = autoV; iackData = ibyte;
      end else if (memReq) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          logic [48:0] e;
          memAck = 1'b1;
          memRData = tableWord(memAddr);
          if (expQ.size() == 0) begin
            chk(1'b0, req, "unexpected bus cycle", memAddr, 32'h0);
          end else begin
            e = expQ.pop_front();
            chk(memWrite == e[48], req, "cycle direction", {31'd0, memWrite}, {31'd0, e[48]});
            chk(memAddr == e[47:16], e[48] ? ((kind == 2'b01) ? "R4" : "R3") : "R5",
                "address", memAddr, e[47:16]);
            if (e[48]) begin
              chk(memWData == e[15:0], (kind == 2'b01) ? "R4" : "R3", "write data",
                  {16'd0, memWData}, {16'd0, e[15:0]});
              chk(memCycleLen == 5'd8, "R9", "write length", {27'd0, memCycleLen}, 32'd8);
            end else begin
              chk(memCycleLen == 5'd8, "R9", "read length", {27'd0, memCycleLen}, 32'd8);
            end
          end
          txn++;
          waitCnt = txn % 3;
        end
      end
    end
    memAck = 1'b0; iackDone = 1'b0; iackBerr = 1'b0; iackAuto = 1'b0;
    chk(gotDone, req, "done seen", {31'd0, gotDone}, 32'd1);
    @(negedge clk);
    chk(busy == 1'b0 && donePulse == 1'b0, "R6", "idle after done", {30'd0, busy, donePulse}, 32'd0);
    chk(a7 == mA7, poke ? "R10" : "R3", "a7 after run", a7, mA7);
    chk(superMode == 1'b1, poke ? "R10" : "R2", "supervisor after run", {31'd0, superMode}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mA7 = 32'h0000_1000; mOther = 32'h0; mSuper = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && memReq == 0 && iackReq == 0 && donePulse == 0, "R1", "idle outputs",
        {28'd0, busy, memReq, iackReq, donePulse}, 32'd0);
    chk(a7 == 32'h1000, "R1", "reset a7", a7, 32'h1000);
    chk(superMode == 1'b1, "R1", "reset mode", {31'd0, superMode}, 32'd1);
    chk(statusOut == 16'h2700, "R1", "reset status", {16'd0, statusOut}, 32'h2700);

    // R12 trap taken in supervisor mode, short frame R3
    runExc(2'b00, 8'd32, 3'd0, 16'hA71F, 32'h0012_3456, 16'h0, 32'h0, 16'h0,
           1'b0, 1'b0, 8'h0, 1'b0, "R12");
    // go to user mode, load user pointer
    modeSet(1'b0);
    spWrite(32'h0000_8000);
    // R4 long frame from user mode with swap R2
    runExc(2'b01, 8'd2, 3'd0, 16'h0015, 32'hCAFE_0100, 16'h1234, 32'h00AB_CDEF, 16'h4E71,
           1'b0, 1'b0, 8'h0, 1'b0, "R4");
    modeSet(1'b0);
    // R7 autovector level 5, R8 mask
    runExc(2'b10, 8'd0, 3'd5, 16'h8003, 32'h0000_2000, 16'h0, 32'h0, 16'h0,
           1'b0, 1'b1, 8'h77, 1'b0, "R7");
    modeSet(1'b0);
    // R7 bus error wins over autovector
    runExc(2'b10, 8'd0, 3'd3, 16'h0000, 32'h0000_3000, 16'h0, 32'h0, 16'h0,
           1'b1, 1'b1, 8'h55, 1'b0, "R7");
    // R7 vector byte, taken in supervisor mode
    runExc(2'b10, 8'd0, 3'd6, 16'h2000, 32'h0000_4000, 16'h0, 32'h0, 16'h0,
           1'b0, 1'b0, 8'h40, 1'b0, "R7");
    // R10 requests, mode change and pointer load ignored while busy
    runExc(2'b11, 8'd47, 3'd0, 16'h2300, 32'h0101_0202, 16'h0, 32'h0, 16'h0,
           1'b0, 1'b0, 8'h0, 1'b1, "R10");
    // R11 round trip restores the user pointer
    modeSet(1'b0);
    modeSet(1'b1);
    modeSet(1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule